// File: doc/BRIEF.md
# Iterative HI/LO Multiply-Divide Unit

This block is the multiply and divide engine that sits next to a 32-bit integer core. It takes signed or unsigned multiply and divide commands, each with two operands. The 64-bit result goes into two result registers, HI and LO. The core can also load either register directly from an operand, and it reads them back over a result bus.

The arithmetic is iterative and handles one bit per cycle. A multiply is a shift-add loop and a divide is a restoring-subtract loop. Both loops run on operand magnitudes, and the signs are applied in a final commit cycle. While an operation runs, the unit raises `busy`. A read request made during that time raises `stall` until the result is ready.

Division by zero and the most-negative-by-minus-one case do not trap. They leave fixed, defined values in HI and LO.

Top module: `mdu_core`

## Requirements
- R1: After reset, HI and LO are both zero. `rd_data` shows LO when `rd_sel`=0 and HI when `rd_sel`=1, with no clock delay.
- R2: Op code 1 (unsigned multiply) leaves the low 32 bits of the 64-bit unsigned product in LO and the high 32 bits in HI.
- R3: Op code 0 (signed multiply) leaves the two's-complement 64-bit product, split the same way as in R2.
- R4: Op code 3 (unsigned divide) leaves the quotient in LO and the remainder in HI. A zero divisor gives LO=0xFFFFFFFF and HI=dividend.
- R5: Op code 2 (signed divide) truncates the quotient toward zero. The remainder carries the sign of the dividend.
- R6: Signed divide by zero gives HI=dividend. LO is 0xFFFFFFFF for a dividend of zero or more, and 1 for a negative dividend.
- R7: Signed 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R8: Op code 4 loads HI from `opa` and op code 5 loads LO from `opa`, both visible one cycle after issue. The other register is unchanged.
- R9: `busy` rises at the edge that accepts an arithmetic command and stays high for exactly 33 cycles (32 iteration steps and one commit). The results can be read once `busy` has fallen.
- R10: `stall` is high while `rd_req` is high and `busy` is high, and low otherwise.
- R11: A command accepted while `busy` is high cancels the running operation. An arithmetic command restarts with the new operands. A move ends `busy` at once, and the register it does not load keeps its value from before the cancelled operation.
- R12: Op codes 6 and 7 are ignored. They change neither `busy`, HI nor LO, and they do not cancel a running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (see R2-R8, R12) |
| opa | input | 32 | First operand: multiplicand, dividend or move value |
| opb | input | 32 | Second operand: multiplier or divisor |
| rd_req | input | 1 | Read request for HI or LO |
| rd_sel | input | 1 | 0 selects LO, 1 selects HI |
| rd_data | output | 32 | Selected result register |
| busy | output | 1 | Operation in progress |
| stall | output | 1 | Read request cannot be served yet |

## Verification
The assertions assume that `cmd_valid` is a single-cycle strobe sampled at the clock edge. They also assume that the operands are only meaningful in the cycle where the strobe is high. The stimulus drives commands at the falling edge and drops the strobe right after the accepting edge, so every command is seen exactly once.

The divider's remainder bound holds only for a non-zero divisor, so that check is gated on the stored divisor. Random operands are mixed with forced zeros and extreme values, so both the gated and the special paths are reached.

// File: rtl/mdu_pkg.sv
// Package: command codes shared by the multiply-divide unit and its users.
// Assumes a 3-bit command field; codes 6 and 7 are reserved and ignored.
package mdu_pkg;
    typedef enum logic [2:0] {
        OP_MULS = 3'd0,
        OP_MULU = 3'd1,
        OP_DIVS = 3'd2,
        OP_DIVU = 3'd3,
        OP_MTHI = 3'd4,
        OP_MTLO = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } mdu_op_e;
endpackage

// File: rtl/mdu_seq_ctrl.sv
// Sequencer: counts ITERS step cycles and then one commit cycle.
// Assumes launch and abort are single-cycle strobes; launch wins over abort.
module mdu_seq_ctrl #(
    parameter int ITERS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic abort,
    output logic busy,
    output logic step,
    output logic commit
);
    localparam int CW = $clog2(ITERS + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Track the position inside the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CW'(ITERS)) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Decode step and commit strobes for the datapath.
    always_comb begin
        busy   = busy_q;
        step   = busy_q && !launch && !abort && (cnt_q < CW'(ITERS));
        commit = busy_q && !launch && !abort && (cnt_q == CW'(ITERS));
    end

    // R9
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !launch) |=> !busy);
endmodule

// File: rtl/mdu_mul_seq.sv
// Shift-add multiplier on unsigned magnitudes, one multiplier bit per step.
// Assumes start and step are never high together.
module mdu_mul_seq #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [XLEN-1:0]   mcand,
    input  logic [XLEN-1:0]   mplier,
    output logic [2*XLEN-1:0] prod
);
    logic [2*XLEN-1:0] acc_q;
    logic [XLEN-1:0]   mcand_q;
    logic [XLEN:0]     sum;

    // Add the multiplicand into the upper half when the low bit is set.
    always_comb begin
        sum = {1'b0, acc_q[2*XLEN-1:XLEN]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    end

    // Load the operands, then shift one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
        end else if (start) begin
            acc_q   <= {{XLEN{1'b0}}, mplier};
            mcand_q <= mcand;
        end else if (step) begin
            acc_q <= {sum, acc_q[XLEN-1:1]};
        end
    end

    assign prod = acc_q;
endmodule

// File: rtl/mdu_div_seq.sv
// Restoring divider on unsigned magnitudes, one quotient bit per step.
// Assumes start and step are never high together. A zero divisor yields
// an all-ones quotient and the dividend as remainder.
module mdu_div_seq #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            step,
    input  logic [XLEN-1:0] dvd,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    logic [XLEN-1:0] q_q, r_q, d_q;
    logic [XLEN:0]   trial, diff;
    logic            fits;

    // Shift in the next dividend bit and try subtracting the divisor.
    always_comb begin
        trial = {r_q, q_q[XLEN-1]};
        diff  = trial - {1'b0, d_q};
        fits  = (trial >= {1'b0, d_q});
    end

    // Load the operands, then produce one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
            r_q <= '0;
            d_q <= '0;
        end else if (start) begin
            q_q <= dvd;
            r_q <= '0;
            d_q <= dvs;
        end else if (step) begin
            r_q <= fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
            q_q <= {q_q[XLEN-2:0], fits};
        end
    end

    assign quo = q_q;
    assign rem = r_q;

    // R5
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && d_q != '0) |=> (r_q < d_q));
endmodule

// File: rtl/mdu_core.sv
// Multiply-divide unit with HI/LO result registers.
// Assumes cmd_valid is a one-cycle strobe. Arithmetic runs 32 steps plus
// a commit cycle; any accepted command cancels a running one.
module mdu_core #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            rd_req,
    input  logic            rd_sel,
    output logic [XLEN-1:0] rd_data,
    output logic            busy,
    output logic            stall
);
    import mdu_pkg::*;

    localparam int ITERS = XLEN;

    mdu_op_e           op;
    logic              is_arith, is_move, launch_mul, launch_div;
    logic              sgn_op, sa, sb;
    logic [XLEN-1:0]   mag_a, mag_b;
    logic              step, commit;
    logic [2*XLEN-1:0] mul_prod, mul_res;
    logic [XLEN-1:0]   div_quo, div_rem;
    logic [XLEN-1:0]   hi_q, lo_q;
    logic              div_q, neg_a_q, neg_x_q, bzero_q;

    // Decode the command and form operand magnitudes.
    always_comb begin
        op         = mdu_op_e'(cmd_op);
        is_arith   = cmd_valid && (op inside {OP_MULS, OP_MULU, OP_DIVS, OP_DIVU});
        is_move    = cmd_valid && (op inside {OP_MTHI, OP_MTLO});
        launch_mul = is_arith && !cmd_op[1];
        launch_div = is_arith && cmd_op[1];
        sgn_op     = (op == OP_MULS) || (op == OP_DIVS);
        sa         = sgn_op && opa[XLEN-1];
        sb         = sgn_op && opb[XLEN-1];
        mag_a      = sa ? (~opa + 1'b1) : opa;
        mag_b      = sb ? (~opb + 1'b1) : opb;
        mul_res    = neg_x_q ? (~mul_prod + 1'b1) : mul_prod;
    end

    mdu_seq_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (is_arith),
        .abort  (is_move),
        .busy   (busy),
        .step   (step),
        .commit (commit)
    );

    mdu_mul_seq #(.XLEN(XLEN)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (launch_mul),
        .step   (step),
        .mcand  (mag_a),
        .mplier (mag_b),
        .prod   (mul_prod)
    );

    mdu_div_seq #(.XLEN(XLEN)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch_div),
        .step  (step),
        .dvd   (mag_a),
        .dvs   (mag_b),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    // Remember the kind and sign fix-up of the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= 1'b0;
            neg_a_q <= 1'b0;
            neg_x_q <= 1'b0;
            bzero_q <= 1'b0;
        end else if (is_arith) begin
            div_q   <= cmd_op[1];
            neg_a_q <= sa;
            neg_x_q <= sa ^ sb;
            bzero_q <= (opb == '0);
        end
    end

    // Update HI/LO from moves or from the commit of a finished operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (is_move) begin
            if (op == OP_MTHI) hi_q <= opa;
            else               lo_q <= opa;
        end else if (commit) begin
            if (div_q) begin
                lo_q <= neg_x_q ? (~div_quo + 1'b1) : div_quo;
                hi_q <= neg_a_q ? (~div_rem + 1'b1) : div_rem;
            end else begin
                lo_q <= mul_res[XLEN-1:0];
                hi_q <= mul_res[2*XLEN-1:XLEN];
            end
        end
    end

    // Drive the read bus and the stall flag.
    always_comb begin
        rd_data = rd_sel ? hi_q : lo_q;
        stall   = rd_req && busy;
    end

    // R4
    divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && div_q && bzero_q) |-> (div_quo == '1));

    // R12
    hilo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[2:1] == 2'b11 && !commit) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/sim_mdu_core.sv
module sim_mdu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] opa = '0, opb = '0;
    logic        rd_req = 1'b0, rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        busy, stall;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ehi = '0, elo = '0;

    always #5 clk = ~clk;

    mdu_core u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected {hi,lo} computed from the requirement text.
    function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            3'd0: begin p = 64'(sa * sb); return p; end
            3'd1: begin p = {32'd0, a} * {32'd0, b}; return p; end
            3'd2: begin
                if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFFFFFF)};
                q = sa / sb; r = sa % sb;
                return {r[31:0], q[31:0]};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFFFFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    task automatic launch(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; opa = a; opb = b;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic readback(input string req);
        rd_req = 1'b1;
        rd_sel = 1'b0; #1; chk({req, " LO"}, rd_data, elo);
        rd_sel = 1'b1; #1; chk({req, " HI"}, rd_data, ehi);
        rd_req = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b);
        logic [63:0] e;
        launch(op, a, b);
        chk("R9 busy after launch", {31'd0, busy}, 32'd1);
        rd_req = 1'b1; #1;
        chk("R10 stall while busy", {31'd0, stall}, 32'd1);
        rd_req = 1'b0;
        repeat (32) @(posedge clk);
        #1;
        chk("R9 busy at cycle 33", {31'd0, busy}, 32'd1);
        @(posedge clk); #1;
        chk("R9 busy drops", {31'd0, busy}, 32'd0);
        rd_req = 1'b1; #1;
        chk("R10 no stall when idle", {31'd0, stall}, 32'd0);
        rd_req = 1'b0;
        e = model(op, a, b);
        ehi = e[63:32]; elo = e[31:0];
        readback(req);
    endtask

    task automatic move(input logic [2:0] op, input logic [31:0] a);
        launch(op, a, 32'd0);
        if (op == 3'd4) ehi = a; else elo = a;
        readback("R8 move");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy reset", {31'd0, busy}, 32'd0);
        readback("R1 reset");

        run_op("R2 mulu", 3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run_op("R2 mulu", 3'd1, 32'h12345678, 32'h9ABCDEF0);
        run_op("R3 muls", 3'd0, 32'hFFFFFFFD, 32'h00000007);
        run_op("R3 muls", 3'd0, 32'h80000000, 32'h80000000);
        run_op("R4 divu", 3'd3, 32'd100, 32'd7);
        run_op("R4 divu zero", 3'd3, 32'hDEADBEEF, 32'd0);
        run_op("R5 divs", 3'd2, 32'hFFFFFF9C, 32'd7);
        run_op("R5 divs", 3'd2, 32'd100, 32'hFFFFFFF9);
        run_op("R6 divs zero pos", 3'd2, 32'd1234, 32'd0);
        run_op("R6 divs zero neg", 3'd2, 32'hFFFFF000, 32'd0);
        run_op("R7 divs ovf", 3'd2, 32'h80000000, 32'hFFFFFFFF);
        move(3'd4, 32'hCAFEF00D);
        move(3'd5, 32'h0BADC0DE);

        // R11 restart: divide cancelled by multiply
        launch(3'd3, 32'd999, 32'd3);
        repeat (5) @(posedge clk);
        run_op("R11 restart", 3'd1, 32'd6, 32'd7);

        // R11 move while busy aborts; HI keeps pre-op value
        launch(3'd1, 32'hFFFF, 32'hFFFF);
        repeat (3) @(posedge clk);
        launch(3'd5, 32'h55AA55AA, 32'd0);
        elo = 32'h55AA55AA;
        chk("R11 abort busy", {31'd0, busy}, 32'd0);
        readback("R11 abort");
        repeat (40) @(posedge clk);
        #1;
        readback("R11 no late commit");

        // R12 reserved codes while idle
        launch(3'd6, 32'h11111111, 32'h2);
        chk("R12 idle busy", {31'd0, busy}, 32'd0);
        readback("R12 idle");
        // R12 reserved code while busy does not cancel
        launch(3'd0, 32'd5, 32'hFFFFFFFE);
        launch(3'd7, 32'h1, 32'h1);
        chk("R12 still busy", {31'd0, busy}, 32'd1);
        repeat (34) @(posedge clk);
        #1;
        ehi = 32'hFFFFFFFF; elo = 32'hFFFFFFF6;
        readback("R12 busy");

        // Random mix
        void'($urandom(32'h5EED));
        for (int i = 0; i < 40; i++) begin
            logic [2:0]  op;
            logic [31:0] a, b;
            op = 3'($urandom_range(0, 3));
            a  = $urandom;
            b  = $urandom;
            if ($urandom_range(0, 7) == 0) b = 32'd0;
            if ($urandom_range(0, 7) == 0) a = 32'h80000000;
            if ($urandom_range(0, 3) == 0) b = b >> $urandom_range(0, 31);
            case (op)
                3'd0: run_op("R3 rand", op, a, b);
                3'd1: run_op("R2 rand", op, a, b);
                3'd2: run_op("R5 rand", op, a, b);
                default: run_op("R4 rand", op, a, b);
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule